// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address-Wait Mode

This block receives asynchronous serial frames on a shared multidrop line. Each frame carries eight data bits plus one extra marker bit. A marker of 1 flags the frame as an address (ID) frame, and a marker of 0 flags it as an ordinary data frame. A station that is not currently being spoken to sets its address-wait control bit. The receiver then throws away every data frame on the line and accepts only the next ID frame. Software compares that byte with its own station address. If the address matches, software keeps receiving. If it does not match, software sets the wait bit once more.

The host sees a small register-style interface:
- a received-byte register;
- three sticky status flags: byte ready, overrun and framing error;
- two control bits: receive enable and address wait;
- a synchronized copy of the line level, so that software can tell a break (line held low) from an ordinary framing error.

A status flag clears only through a read-then-write-zero sequence. While an error flag is set, reception is locked. The bit clock is a fixed divide of the system clock, and the line is sampled at sixteen times the bit rate.

Top module: `mp_serial_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits sent least significant bit first, one marker bit, then one stop bit, at 16 samples per bit. When a good frame is accepted, its byte appears on `rxData` and `dataReady` goes to 1.
- R2: A low pulse that ends before the middle of the start bit (shorter than 8 samples) does not start a frame, and it changes no output.
- R3: While `idWait` is 1, a frame whose marker bit is 0 is discarded. `rxData` and all flags stay unchanged, and `idWait` stays 1.
- R4: While `idWait` is 1, a frame whose marker bit is 1 is accepted and `idWait` returns to 0 by itself. Frames with marker 0 that follow are then accepted normally. Writing `idWait` to 1 again restores the discarding of R3.
- R5: If a good frame completes while `dataReady` is 1, `overrun` goes to 1. The new byte is dropped, and `rxData` keeps the earlier byte.
- R6: If the stop bit is sampled low, `frameErr` goes to 1 and the byte of that frame is not transferred.
- R7: While `overrun` or `frameErr` is 1, no frame is accepted. Reception restarts only after both flags are 0.
- R8: `lineLevel` follows `rxLine` through a two-stage synchronizer, so a held-low break reads as 0.
- R9: While `rxEnable` is 0, frames are ignored. A control write takes `rxEnable` from `ctrlWrData` bit 0 and `idWait` from bit 1.
- R10: A status write clears a flag only where `statWrData` holds 0 and the flag was 1 at an earlier `statRead`. The bit positions are: bit 0 is `dataReady`, bit 1 is `overrun`, bit 2 is `frameErr`. A write without that earlier read clears nothing, and writing 1 to a bit leaves that flag unchanged.
- R11: After reset, `rxData` is 0, all three flags are 0, `rxEnable` is 0, `idWait` is 0 and `lineLevel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial receive line, idles high |
| statRead | input | 1 | Host read of the status flags (one-cycle pulse) |
| statWrite | input | 1 | Host write of the status flags (one-cycle pulse) |
| statWrData | input | 3 | Status write value; a 0 clears the matching flag if it was read set |
| ctrlWrite | input | 1 | Host write of the control bits (one-cycle pulse) |
| ctrlWrData | input | 2 | Bit 0 is receive enable, bit 1 is address wait |
| rxData | output | 8 | Last accepted byte |
| dataReady | output | 1 | Byte-ready flag |
| overrun | output | 1 | Overrun flag |
| frameErr | output | 1 | Framing-error flag |
| rxEnable | output | 1 | Receive enable control bit |
| idWait | output | 1 | Address-wait control bit |
| lineLevel | output | 1 | Synchronized line level |

## Verification
Frames are sent with different byte values and both marker values, and with the receiver disabled, waiting for an address, or in normal mode. This separates the discard done by the address wait from the discard caused by disable or lock. A second frame sent while the ready flag is still set shows the difference between an overrun and a normal load. A frame with a low stop bit shows the difference between a framing error and an overrun. A short start glitch shows whether the start bit is confirmed at mid-bit. Clear writes sent before and after a status read show that the read-then-write order is enforced.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_RDY  = 0;
  localparam int FLAG_OVR  = 1;
  localparam int FLAG_FER  = 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS
  } rxState_t;

  typedef struct packed {
    logic restartCnt;
    logic shiftBit;
    logic loadData;
  } rxStrobes_t;

endpackage

// File: rtl/mprx_datapath.sv
module mprx_datapath
  import mprx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int CLKS_PER_TICK = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobes_t           strobes,
  output logic                 tick,
  output logic                 midPoint,
  output logic                 bitPoint,
  output logic                 lineSync,
  output logic                 frameMpb,
  output logic [DATA_BITS-1:0] rxData
);

  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam int SHIFT_W = DATA_BITS + 1;
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVERSAMPLE - 1);

  // Line synchronizer; idle level is high
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  // Oversample tick generator
  generate
    if (CLKS_PER_TICK > 1) begin : g_div
      localparam int DIV_W = $clog2(CLKS_PER_TICK);
      localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CLKS_PER_TICK - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divCnt <= '0;
        else if (divCnt == DIV_END) divCnt <= '0;
        else                      divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = (divCnt == DIV_END);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Sample position within a bit
  logic [CNT_W-1:0] sampCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sampCnt <= '0;
    else if (strobes.restartCnt) sampCnt <= '0;
    else if (tick)               sampCnt <= sampCnt + CNT_W'(1);
  end
  assign midPoint = tick && (sampCnt == MID_CNT);
  assign bitPoint = tick && (sampCnt == END_CNT);

  // Shift register: data bits enter at the top, marker bit last
  logic [SHIFT_W-1:0] shiftReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobes.shiftBit) shiftReg <= {lineSync, shiftReg[SHIFT_W-1:1]};
  end
  assign frameMpb = shiftReg[SHIFT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxData <= '0;
    else if (strobes.loadData) rxData <= shiftReg[DATA_BITS-1:0];
  end

  // R1: the register takes the byte that was assembled
  a_r1_load_copies_shift: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadData) |-> rxData == $past(shiftReg[DATA_BITS-1:0]));

endmodule

// File: rtl/mprx_control.sv
module mprx_control
  import mprx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       midPoint,
  input  logic       bitPoint,
  input  logic       lineSync,
  input  logic       frameMpb,
  input  logic       statRead,
  input  logic       statWrite,
  input  logic [2:0] statWrData,
  input  logic       ctrlWrite,
  input  logic [1:0] ctrlWrData,
  output rxStrobes_t strobes,
  output logic       dataReady,
  output logic       overrun,
  output logic       frameErr,
  output logic       rxEnable,
  output logic       idWait
);

  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  rxState_t             state;
  logic [IDX_W-1:0]     bitIdx;
  logic [NUM_FLAGS-1:0] flagQ, armQ, setV, clrV;

  logic locked, runOk, frameDone, acceptFrame;

  assign locked    = flagQ[FLAG_OVR] | flagQ[FLAG_FER];
  assign runOk     = rxEnable && !locked;
  assign frameDone = (state == RX_BITS) && bitPoint && (bitIdx == STOP_IDX);
  // Marker-0 frames are skipped during address wait
  assign acceptFrame = frameDone && lineSync && !(idWait && !frameMpb);

  always_comb begin
    strobes.restartCnt = ((state == RX_IDLE) && tick && !lineSync && runOk) ||
                         ((state == RX_START) && midPoint);
    strobes.shiftBit   = (state == RX_BITS) && bitPoint && (bitIdx != STOP_IDX);
    strobes.loadData   = acceptFrame && !flagQ[FLAG_RDY];
  end

  // Bit-level sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitIdx <= '0;
    end else if (!runOk) begin
      state <= RX_IDLE;
    end else begin
      case (state)
        RX_IDLE:  if (tick && !lineSync) state <= RX_START;
        RX_START: if (midPoint) begin
                    state  <= lineSync ? RX_IDLE : RX_BITS;
                    bitIdx <= '0;
                  end
        RX_BITS:  if (bitPoint) begin
                    if (bitIdx == STOP_IDX) state <= RX_IDLE;
                    else bitIdx <= bitIdx + IDX_W'(1);
                  end
        default:  state <= RX_IDLE;
      endcase
    end
  end

  // Sticky status flags with read-then-write-zero clearing
  assign setV[FLAG_RDY] = strobes.loadData;
  assign setV[FLAG_OVR] = acceptFrame && flagQ[FLAG_RDY];
  assign setV[FLAG_FER] = frameDone && !lineSync;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      assign clrV[i] = statWrite && !statWrData[i] && armQ[i];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagQ[i] <= 1'b0;
          armQ[i]  <= 1'b0;
        end else begin
          if (setV[i])      flagQ[i] <= 1'b1;
          else if (clrV[i]) flagQ[i] <= 1'b0;
          if (!flagQ[i] || clrV[i]) armQ[i] <= 1'b0;
          else if (statRead)        armQ[i] <= 1'b1;
        end
      end
    end
  endgenerate

  assign dataReady = flagQ[FLAG_RDY];
  assign overrun   = flagQ[FLAG_OVR];
  assign frameErr  = flagQ[FLAG_FER];

  // Control bits; the hardware drops address wait once an ID byte lands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable <= 1'b0;
      idWait   <= 1'b0;
    end else if (ctrlWrite) begin
      rxEnable <= ctrlWrData[0];
      idWait   <= ctrlWrData[1];
    end else if (strobes.loadData && frameMpb) begin
      idWait <= 1'b0;
    end
  end

  // R9: disabled receiver sits idle
  a_r9_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rxEnable) |-> state == RX_IDLE);

  // R7: a locked receiver does not run the sequencer
  a_r7_locked_idle: assert property (@(posedge clk) disable iff (!rstN)
    (overrun || frameErr) |-> state == RX_IDLE);

  // R10: overrun only falls after it was read as set
  a_r10_clear_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(armQ[FLAG_OVR]));

  // R4: address wait ends by hardware only on an accepted ID byte
  a_r4_idwait_hw_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(idWait) && !$past(ctrlWrite)) |-> $past(strobes.loadData && frameMpb));

endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
  import mprx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int CLKS_PER_TICK = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 statRead,
  input  logic                 statWrite,
  input  logic [2:0]           statWrData,
  input  logic                 ctrlWrite,
  input  logic [1:0]           ctrlWrData,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 overrun,
  output logic                 frameErr,
  output logic                 rxEnable,
  output logic                 idWait,
  output logic                 lineLevel
);

  rxStrobes_t ctrlStrobes;
  logic tick, midPoint, bitPoint, lineSync, frameMpb;

  mprx_datapath #(
    .DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE),
    .CLKS_PER_TICK(CLKS_PER_TICK), .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobes(ctrlStrobes),
    .tick(tick), .midPoint(midPoint), .bitPoint(bitPoint),
    .lineSync(lineSync), .frameMpb(frameMpb), .rxData(rxData)
  );

  mprx_control #(.DATA_BITS(DATA_BITS)) uControl (
    .clk(clk), .rstN(rstN), .tick(tick), .midPoint(midPoint),
    .bitPoint(bitPoint), .lineSync(lineSync), .frameMpb(frameMpb),
    .statRead(statRead), .statWrite(statWrite), .statWrData(statWrData),
    .ctrlWrite(ctrlWrite), .ctrlWrData(ctrlWrData), .strobes(ctrlStrobes),
    .dataReady(dataReady), .overrun(overrun), .frameErr(frameErr),
    .rxEnable(rxEnable), .idWait(idWait)
  );

  assign lineLevel = lineSync;

  // R1: ready flag rises only with a byte load
  a_r1_ready_from_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(ctrlStrobes.loadData));

  // R5: an unread byte is never overwritten
  a_r5_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && $past(dataReady)) |-> $stable(rxData));

endmodule

// File: tb/tb_mp_serial_rx.sv
`timescale 1ns/1ps
module tb_mp_serial_rx;

  localparam int BIT_CLKS = 64;   // 16 samples x 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       statRead = 1'b0, statWrite = 1'b0, ctrlWrite = 1'b0;
  logic [2:0] statWrData = '0;
  logic [1:0] ctrlWrData = '0;
  logic [7:0] rxData;
  logic       dataReady, overrun, frameErr, rxEnable, idWait, lineLevel;

  always #2 clk = ~clk;

  mp_serial_rx dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .statRead(statRead),
    .statWrite(statWrite), .statWrData(statWrData), .ctrlWrite(ctrlWrite),
    .ctrlWrData(ctrlWrData), .rxData(rxData), .dataReady(dataReady),
    .overrun(overrun), .frameErr(frameErr), .rxEnable(rxEnable),
    .idWait(idWait), .lineLevel(lineLevel)
  );

  int testsRun = 0, testsFailed = 0, printed = 0;
  bit busy = 1'b1, running = 1'b0, finished = 1'b0;

  // Reference model state
  logic [7:0] mData = '0;
  bit mRdy, mOvr, mFer, mEn, mIdw;
  bit [2:0] mArm;

  task automatic chkEq(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, outside frame windows
  always @(negedge clk) begin
    if (running && !busy) begin
      logic [12:0] act, exp;
      act = {rxData, dataReady, overrun, frameErr, rxEnable, idWait};
      exp = {mData, mRdy, mOvr, mFer, mEn, mIdw};
      testsRun++;
      if (act != exp) begin
        testsFailed++;
        if (printed < 20) begin
          printed++;
          $display("FAIL model compare (R1,R3-R7,R9,R10) at %0t actual=%0h expected=%0h",
                   $time, act, exp);
        end
      end
    end
  end

  task automatic modelFrame(input logic [7:0] d, input bit mpb, input bit stopVal);
    if (!mEn || mOvr || mFer) return;
    if (!stopVal) mFer = 1'b1;
    else if (mIdw && !mpb) return;
    else if (mRdy) mOvr = 1'b1;
    else begin
      mData = d;
      mRdy  = 1'b1;
      mIdw  = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit mpb, input bit stopVal);
    busy = 1'b1;
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxLine = mpb;
    repeat (BIT_CLKS) @(negedge clk);
    rxLine = stopVal;
    repeat (BIT_CLKS) @(negedge clk);
    rxLine = 1'b1;
    modelFrame(d, mpb, stopVal);
    busy = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic hostRead();
    statRead = 1'b1;
    @(posedge clk);
    if (mRdy) mArm[0] = 1'b1;
    if (mOvr) mArm[1] = 1'b1;
    if (mFer) mArm[2] = 1'b1;
    @(negedge clk);
    statRead = 1'b0;
  endtask

  task automatic hostWriteStat(input logic [2:0] v);
    statWrite = 1'b1;
    statWrData = v;
    @(posedge clk);
    if (!v[0] && mArm[0]) begin mRdy = 1'b0; mArm[0] = 1'b0; end
    if (!v[1] && mArm[1]) begin mOvr = 1'b0; mArm[1] = 1'b0; end
    if (!v[2] && mArm[2]) begin mFer = 1'b0; mArm[2] = 1'b0; end
    @(negedge clk);
    statWrite = 1'b0;
  endtask

  task automatic hostWriteCtrl(input bit en, input bit idw);
    ctrlWrite = 1'b1;
    ctrlWrData = {idw, en};
    @(posedge clk);
    mEn = en;
    mIdw = idw;
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;
    busy = 1'b0;

    // R11: reset state
    chkEq("R11 rxData", rxData, 0);
    chkEq("R11 flags", {dataReady, overrun, frameErr}, 0);
    chkEq("R11 controls", {rxEnable, idWait}, 0);
    chkEq("R11 lineLevel", lineLevel, 1);

    // R9: disabled receiver ignores a frame
    sendFrame(8'h5A, 1'b0, 1'b1);
    chkEq("R9 disabled no ready", dataReady, 0);

    hostWriteCtrl(1'b1, 1'b0);
    chkEq("R9 enable bit", rxEnable, 1);

    // R1: normal reception
    sendFrame(8'hA5, 1'b0, 1'b1);
    chkEq("R1 byte A5", rxData, 8'hA5);
    chkEq("R1 ready set", dataReady, 1);

    // R10: write zero without a read, then write one after a read
    hostWriteStat(3'b110);
    chkEq("R10 no clear without read", dataReady, 1);
    hostRead();
    hostWriteStat(3'b111);
    chkEq("R10 write one keeps flag", dataReady, 1);
    hostWriteStat(3'b110);
    chkEq("R10 read then zero clears", dataReady, 0);

    // R1: another pattern with both edge bits set
    sendFrame(8'h81, 1'b1, 1'b1);
    chkEq("R1 byte 81", rxData, 8'h81);
    hostRead();
    hostWriteStat(3'b110);

    // R2: short start glitch
    busy = 1'b1;
    rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    busy = 1'b0;
    chkEq("R2 glitch no ready", dataReady, 0);
    chkEq("R2 glitch data kept", rxData, 8'h81);

    // R3: address wait skips marker-0 frames
    hostWriteCtrl(1'b1, 1'b1);
    sendFrame(8'h33, 1'b0, 1'b1);
    chkEq("R3 data frame skipped", dataReady, 0);
    chkEq("R3 data unchanged", rxData, 8'h81);
    chkEq("R3 wait kept", idWait, 1);

    // R4: ID frame accepted, wait ends, data follows
    sendFrame(8'h4E, 1'b1, 1'b1);
    chkEq("R4 id byte", rxData, 8'h4E);
    chkEq("R4 wait cleared", idWait, 0);
    hostRead();
    hostWriteStat(3'b110);
    sendFrame(8'h3C, 1'b0, 1'b1);
    chkEq("R4 data after id", rxData, 8'h3C);
    hostRead();
    hostWriteStat(3'b110);
    hostWriteCtrl(1'b1, 1'b1);
    sendFrame(8'h44, 1'b0, 1'b1);
    chkEq("R4 rearmed wait skips", dataReady, 0);
    hostWriteCtrl(1'b1, 1'b0);

    // R5: overrun
    sendFrame(8'h11, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b1);
    chkEq("R5 overrun set", overrun, 1);
    chkEq("R5 old byte kept", rxData, 8'h11);

    // R7: locked by overrun
    sendFrame(8'h99, 1'b0, 1'b1);
    chkEq("R7 locked byte kept", rxData, 8'h11);
    hostRead();
    hostWriteStat(3'b100);
    chkEq("R7 flags cleared", {dataReady, overrun}, 0);
    sendFrame(8'h77, 1'b0, 1'b1);
    chkEq("R7 resumed", rxData, 8'h77);
    hostRead();
    hostWriteStat(3'b110);

    // R6: framing error
    sendFrame(8'h66, 1'b0, 1'b0);
    chkEq("R6 frameErr set", frameErr, 1);
    chkEq("R6 no transfer", {dataReady, rxData}, {1'b0, 8'h77});

    // R8: break level visible
    rxLine = 1'b0;
    repeat (200) @(negedge clk);
    chkEq("R8 break low", lineLevel, 0);
    rxLine = 1'b1;
    repeat (3) @(negedge clk);
    chkEq("R8 line high", lineLevel, 1);

    // R7: locked by framing error, then resume
    sendFrame(8'h12, 1'b0, 1'b1);
    chkEq("R7 locked by frameErr", dataReady, 0);
    hostRead();
    hostWriteStat(3'b011);
    chkEq("R10 frameErr cleared", frameErr, 0);
    sendFrame(8'h12, 1'b0, 1'b1);
    chkEq("R7 resume after frameErr", rxData, 8'h12);
    hostRead();
    hostWriteStat(3'b110);

    // R9: disable stops reception
    hostWriteCtrl(1'b0, 1'b0);
    sendFrame(8'h55, 1'b0, 1'b1);
    chkEq("R9 disabled ignores", {dataReady, rxData}, {1'b0, 8'h12});

    repeat (10) @(negedge clk);
    finish();
  end

endmodule